// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps one address reservation for a single processor, so that a load-linked and a later store-conditional together act as one atomic read-modify-write. A load-linked request stores the 64-byte line it touched and raises a hidden link flag. A store-conditional reaches memory only while that flag is still up and its address falls in the same line. The block reports success or failure in the same cycle, so software can branch back and retry.

The reservation drops when a snooped coherence invalidate hits the reserved line, when the core signals a context switch or exception, or when any store-conditional is issued. A new load-linked replaces any older reservation. The memory-write enable for a store-conditional comes from this block, and it stays low for every store-conditional that fails.

Top module: `resv_monitor`

## Requirements
- R1: After reset the link is clear, and `mem_we`, `sc_ok` and `sc_fail` are low.
- R2: A request with `req_kind` = 2'b01 (load-linked) raises `link_o` on the next cycle and records address bits [31:6] as the reserved line.
- R3: A request with `req_kind` = 2'b10 (store-conditional) raises `sc_ok` and `mem_we` in the same cycle when the link is set, its line matches the reserved line and no break event arrives in that cycle.
- R4: A store-conditional whose line differs from the reserved line fails, even with the link set.
- R5: Every store-conditional that does not succeed raises `sc_fail` and keeps `mem_we` low. `sc_ok` and `sc_fail` are never high together.
- R6: Any store-conditional, whether it passes or fails, clears the link on the next cycle.
- R7: A snooped invalidate (`snoop_inv` high) whose address bits [31:6] equal the reserved line clears the link. An invalidate to another line leaves the link as it was.
- R8: `ctx_flush` clears the link on the next cycle, and a store-conditional in the same cycle fails.
- R9: A new load-linked replaces the older reservation, so a store-conditional to the old line then fails.
- R10: Address bits [5:0] are ignored wherever addresses are matched.
- R11: A store-conditional fails when an invalidate to the reserved line arrives in the same cycle.
- R12: A load-linked in the same cycle as `ctx_flush`, or as an invalidate to its own new line, leaves the link clear.
- R13: `req_kind` = 2'b11 and 2'b00 change nothing: the link stays as it was and `mem_we` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_kind | input | 2 | 00 idle, 01 load-linked, 10 store-conditional, 11 reserved |
| req_addr | input | 32 | Byte address of the request |
| snoop_inv | input | 1 | A coherence invalidate is present this cycle |
| snoop_addr | input | 32 | Byte address of the invalidate |
| ctx_flush | input | 1 | Context switch or exception; drops the reservation |
| mem_we | output | 1 | Memory write enable for a passing store-conditional |
| sc_ok | output | 1 | Store-conditional succeeded this cycle |
| sc_fail | output | 1 | Store-conditional failed this cycle |
| link_o | output | 1 | Current state of the link flag |

## Verification
Directed sequences pair each load-linked with a store-conditional in several ways. The store goes to the same line through a different byte offset, to a neighbouring line, after an invalidate to the reserved line or to an unrelated line, after a flush, or after a second load-linked. Each case separates one break or match condition from the others. Events that arrive in the same cycle, such as an invalidate or flush together with a store-conditional or a load-linked, show the chosen priority. A long pseudo-random stream over a few nearby lines, checked against a behavioural model on every cycle, exercises mixes that the directed cases do not reach.

// File: rtl/resv_pkg.sv
package resv_pkg;
    typedef enum logic [1:0] {
        REQ_IDLE = 2'b00,
        REQ_LL   = 2'b01,
        REQ_SC   = 2'b10,
        REQ_RSVD = 2'b11
    } req_kind_e;
endpackage

// File: rtl/resv_line_cmp.sv
module resv_line_cmp #(
    parameter int ADDR_W   = 32,
    parameter int LINE_OFS = 6,
    localparam int LINE_W  = ADDR_W - LINE_OFS
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LINE_W-1:0] line,
    output logic              hit
);
    logic [LINE_W-1:0] addr_line;

    generate
        if (LINE_OFS > 0) begin : g_strip
            assign addr_line = addr[ADDR_W-1:LINE_OFS];
        end else begin : g_full
            assign addr_line = addr;
        end
    endgenerate

    assign hit = en && (addr_line == line);
endmodule

// File: rtl/resv_break_unit.sv
module resv_break_unit #(
    parameter int ADDR_W   = 32,
    parameter int LINE_OFS = 6,
    localparam int LINE_W  = ADDR_W - LINE_OFS
) (
    input  logic              snoop_inv,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              ctx_flush,
    input  logic [LINE_W-1:0] held_line,
    input  logic [LINE_W-1:0] new_line,
    output logic              kill_held,
    output logic              kill_new
);
    logic snp_hit_held;
    logic snp_hit_new;

    resv_line_cmp #(.ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS)) u_cmp_held (
        .en   (snoop_inv),
        .addr (snoop_addr),
        .line (held_line),
        .hit  (snp_hit_held)
    );

    resv_line_cmp #(.ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS)) u_cmp_new (
        .en   (snoop_inv),
        .addr (snoop_addr),
        .line (new_line),
        .hit  (snp_hit_new)
    );

    always_comb begin
        kill_held = ctx_flush || snp_hit_held;
        kill_new  = ctx_flush || snp_hit_new;
    end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
    parameter int ADDR_W   = 32,
    parameter int LINE_OFS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              snoop_inv,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              ctx_flush,
    output logic              mem_we,
    output logic              sc_ok,
    output logic              sc_fail,
    output logic              link_o
);
    import resv_pkg::*;

    localparam int LINE_W = ADDR_W - LINE_OFS;

    typedef struct packed {
        logic              link;
        logic [LINE_W-1:0] line;
    } resv_state_t;

    resv_state_t state_d, state_q;
    req_kind_e   kind;
    logic        is_ll, is_sc;
    logic        sc_line_hit;
    logic        kill_held, kill_new;
    logic [LINE_W-1:0] req_line;

    assign kind     = req_kind_e'(req_kind);
    assign is_ll    = (kind == REQ_LL);
    assign is_sc    = (kind == REQ_SC);
    assign req_line = req_addr[ADDR_W-1:LINE_OFS];

    resv_line_cmp #(.ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS)) u_sc_cmp (
        .en   (is_sc),
        .addr (req_addr),
        .line (state_q.line),
        .hit  (sc_line_hit)
    );

    resv_break_unit #(.ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS)) u_break (
        .snoop_inv  (snoop_inv),
        .snoop_addr (snoop_addr),
        .ctx_flush  (ctx_flush),
        .held_line  (state_q.line),
        .new_line   (req_line),
        .kill_held  (kill_held),
        .kill_new   (kill_new)
    );

    always_comb begin
        state_d = state_q;
        sc_ok   = is_sc && sc_line_hit && state_q.link && !kill_held;
        sc_fail = is_sc && !sc_ok;
        mem_we  = sc_ok;
        if (is_ll) begin
            state_d.line = req_line;
            state_d.link = !kill_new;
        end else if (is_sc || kill_held) begin
            state_d.link = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign link_o = state_q.link;
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] req_kind,
    input logic       snoop_inv,
    input logic       ctx_flush,
    input logic       mem_we,
    input logic       sc_ok,
    input logic       sc_fail,
    input logic       link_o
);
    assert_fail_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sc_fail |-> !mem_we);
    assert_ok_fail_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sc_ok && sc_fail));
    assert_ok_needs_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sc_ok |-> link_o);
    assert_sc_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_kind == 2'b10) |=> !link_o);
    assert_ll_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_kind == 2'b01 && !ctx_flush && !snoop_inv) |=> link_o);
    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_flush && req_kind != 2'b01) |=> !link_o);
    assert_flush_blocks_sc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_flush |-> !mem_we);
    assert_write_only_sc_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (req_kind == 2'b10));
    assert_idle_keeps_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_kind[0] == req_kind[1] && !ctx_flush && !snoop_inv) |=> $stable(link_o));
endmodule

bind resv_monitor resv_monitor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_kind  (req_kind),
    .snoop_inv (snoop_inv),
    .ctx_flush (ctx_flush),
    .mem_we    (mem_we),
    .sc_ok     (sc_ok),
    .sc_fail   (sc_fail),
    .link_o    (link_o)
);

// File: tb/resv_monitor_bench.sv
`timescale 1ns/1ps
module resv_monitor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [31:0] req_addr = '0;
    logic        snoop_inv = 1'b0;
    logic [31:0] snoop_addr = '0;
    logic        ctx_flush = 1'b0;
    logic        mem_we, sc_ok, sc_fail, link_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit          m_link = 1'b0;
    logic [25:0] m_line = '0;

    always #2.5 clk = ~clk;

    resv_monitor u_resv_monitor (
        .clk(clk), .rst_n(rst_n), .req_kind(req_kind), .req_addr(req_addr),
        .snoop_inv(snoop_inv), .snoop_addr(snoop_addr), .ctx_flush(ctx_flush),
        .mem_we(mem_we), .sc_ok(sc_ok), .sc_fail(sc_fail), .link_o(link_o)
    );

    task automatic cmp(string tag, string sig, logic act, logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, sig, act, exp, $time);
        end
    endtask

    // drive one cycle, compare outputs, advance the model
    task automatic step(string tag, logic [1:0] k, logic [31:0] a,
                        logic sv, logic [31:0] sa, logic fl);
        bit exp_ok, snp_old, snp_new;
        @(negedge clk);
        req_kind = k; req_addr = a; snoop_inv = sv; snoop_addr = sa; ctx_flush = fl;
        #1;
        snp_old = sv && (sa[31:6] == m_line);
        snp_new = sv && (sa[31:6] == a[31:6]);
        exp_ok  = (k == 2'b10) && m_link && (a[31:6] == m_line) && !fl && !snp_old;
        cmp(tag, "link_o", link_o, m_link);
        cmp(tag, "sc_ok", sc_ok, exp_ok);
        cmp(tag, "sc_fail", sc_fail, (k == 2'b10) && !exp_ok);
        cmp(tag, "mem_we", mem_we, exp_ok);
        if (k == 2'b01) begin
            m_line = a[31:6];
            m_link = !fl && !snp_new;
        end else if (k == 2'b10 || fl || snp_old) begin
            m_link = 1'b0;
        end
    endtask

    task automatic idle(string tag);
        step(tag, 2'b00, 32'h0, 1'b0, 32'h0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : main
        int seed;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp("R1", "link_o", link_o, 1'b0);
        cmp("R1", "mem_we", mem_we, 1'b0);
        cmp("R1", "sc_ok", sc_ok, 1'b0);
        cmp("R1", "sc_fail", sc_fail, 1'b0);
        rst_n = 1'b1;
        idle("R1");

        // SC with no reservation
        step("R5", 2'b10, 32'h0000_1000, 0, 0, 0);
        // LL then SC to same line, other offset
        step("R2", 2'b01, 32'h0000_1000, 0, 0, 0);
        step("R10", 2'b10, 32'h0000_1034, 0, 0, 0);
        step("R6", 2'b10, 32'h0000_1000, 0, 0, 0);
        // mismatched line
        step("R2", 2'b01, 32'h0000_2000, 0, 0, 0);
        step("R4", 2'b10, 32'h0000_2040, 0, 0, 0);
        idle("R6");
        // matching snoop with offset bits set
        step("R2", 2'b01, 32'h0000_3000, 0, 0, 0);
        step("R7", 2'b00, 32'h0, 1, 32'h0000_303F, 0);
        step("R7", 2'b10, 32'h0000_3000, 0, 0, 0);
        // unrelated snoop
        step("R2", 2'b01, 32'h0000_4000, 0, 0, 0);
        step("R7", 2'b00, 32'h0, 1, 32'h0000_4040, 0);
        step("R3", 2'b10, 32'h0000_4008, 0, 0, 0);
        // flush
        step("R2", 2'b01, 32'h0000_6000, 0, 0, 0);
        step("R8", 2'b00, 32'h0, 0, 0, 1);
        step("R8", 2'b10, 32'h0000_6000, 0, 0, 0);
        // replacement
        step("R2", 2'b01, 32'h0000_7000, 0, 0, 0);
        step("R9", 2'b01, 32'h0000_8000, 0, 0, 0);
        step("R9", 2'b10, 32'h0000_7000, 0, 0, 0);
        step("R2", 2'b01, 32'h0000_8000, 0, 0, 0);
        step("R9", 2'b10, 32'h0000_8010, 0, 0, 0);
        // same-cycle snoop / flush with SC
        step("R2", 2'b01, 32'h0000_9000, 0, 0, 0);
        step("R11", 2'b10, 32'h0000_9000, 1, 32'h0000_9020, 0);
        step("R2", 2'b01, 32'h0000_9000, 0, 0, 0);
        step("R8", 2'b10, 32'h0000_9000, 0, 0, 1);
        // same-cycle flush / snoop with LL
        step("R12", 2'b01, 32'h0000_A000, 0, 0, 1);
        step("R12", 2'b10, 32'h0000_A000, 0, 0, 0);
        step("R12", 2'b01, 32'h0000_B000, 1, 32'h0000_B004, 0);
        step("R12", 2'b10, 32'h0000_B000, 0, 0, 0);
        // LL survives a snoop to the line it replaces
        step("R2", 2'b01, 32'h0000_C000, 0, 0, 0);
        step("R9", 2'b01, 32'h0000_D000, 1, 32'h0000_C000, 0);
        step("R9", 2'b10, 32'h0000_D000, 0, 0, 0);
        // reserved and idle codes
        step("R2", 2'b01, 32'h0000_E000, 0, 0, 0);
        step("R13", 2'b11, 32'h0000_E000, 0, 0, 0);
        step("R13", 2'b00, 32'h0000_E000, 0, 0, 0);
        step("R13", 2'b10, 32'h0000_E000, 0, 0, 0);

        // pseudo-random mix over four nearby lines
        seed = 32'h1357;
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, sa;
            logic [1:0]  k;
            logic        sv, fl;
            seed = seed * 1103515245 + 12345;
            k  = seed[17:16];
            a  = {24'h0, seed[21:20], seed[9:4]} + 32'h0001_0000;
            sa = {24'h0, seed[25:24], seed[13:8]} + 32'h0001_0000;
            sv = (seed[28:26] == 3'd0);
            fl = (seed[30:27] == 4'd0);
            step("R3/R7 random", k, a, sv, sa, fl);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule